// File: doc/BRIEF.md
# Trap Priority and Conflict Controller

This block collects exception requests from the fault detectors and from the arithmetic unit. It holds each request as a pending bit and picks the most urgent one by fixed priority. It then hands the fetch unit the address of that trap's vector slot. Eight trap levels are handled, with request bit i standing for priority level 8+i. Bits 0 to 3 are soft traps, and bit 3 is the arithmetic error. Bits 4 to 7 are hard traps: bit 4 is the address error, bit 5 the stack error, bit 6 the oscillator failure, and bit 7 is the top hard level. A select input chooses between two vector tables. The primary table starts at 0x000004 and the alternate table at 0x000084. Slots are two address units apart and ordered by level, so the first peripheral slot falls at 0x000014 or 0x000094.

A dispatched hard trap stops execution until the acknowledge strobe arrives. After that it stays in service until the trap-return strobe. A dispatched soft trap goes straight into service. Only one trap is in service at a time; the others wait as pending bits that software can read.

A hard request whose level is below a hard trap that is already pending, waiting for acknowledge, or in service is a conflict. It is not queued. Instead the controller raises a one-cycle reset request, clears itself, and sets a sticky conflict flag. Only the flag-clear input (a software write) clears that flag.

Top module: `trap_arbiter`

## Requirements
- R1: While rstN is low and after its release, vecValid, stall, rstReq, trapRstFlag and every trapPending bit are 0.
- R2: A request on trapReq bit i sets trapPending bit i (level 8+i) in the cycle after it is sampled. The bit stays set until that trap is dispatched or a conflict clears it.
- R3: When idle with any bit pending, the controller dispatches the highest-numbered pending bit, clears only that bit, and leaves the others pending.
- R4: A dispatch gives a one-cycle vecValid pulse one clock after the pending bit is visible. vecAddr is 0x000004 + 2*i when altSel is 0, or 0x000084 + 2*i when altSel is 1, with altSel sampled at the dispatch edge.
- R5: After a hard trap (bits 4 to 7) is dispatched, stall stays high until ack is sampled. After ack, stall is low.
- R6: While idle, stall is high whenever any hard bit (4 to 7) is pending.
- R7: No further dispatch happens until trapRet is sampled in service. A trapRet while waiting for ack is ignored, and an ack outside the wait for ack is ignored.
- R8: A hard request at bit i conflicts when a trap with a higher bit is in service or waiting for ack, or when a higher bit is already pending. On a conflict, rstReq is high for exactly the next cycle, all pending bits clear and the controller returns to idle.
- R9: Hard requests that arrive in the same cycle do not conflict, and a higher hard request arriving while a lower one is active does not conflict; it stays pending.
- R10: trapRstFlag is set by a conflict and holds until flagClr is sampled with no conflict in the same cycle. A conflict in the same cycle as flagClr leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 8 | Trap request pulses, bit i = level 8+i |
| altSel | input | 1 | 1 selects the alternate vector table |
| ack | input | 1 | Hard trap acknowledge strobe |
| trapRet | input | 1 | Return-from-trap strobe |
| flagClr | input | 1 | Software clear of the conflict flag |
| vecValid | output | 1 | One-cycle pulse with a new vector address |
| vecAddr | output | 24 | Vector slot address of the dispatched trap |
| stall | output | 1 | Holds off execution |
| rstReq | output | 1 | Device reset request after a conflict |
| trapRstFlag | output | 1 | Sticky conflict-reset status |
| trapPending | output | 8 | Pending trap bits |

## Verification
The assertions assume that ack and trapRet are single-cycle strobes from the execution side. They also assume that flagClr is never held high across a conflict except where the bench deliberately tests that set wins over clear. The stimulus drives every strobe for exactly one cycle, away from the clock edge. It only issues ack and trapRet in the states where they are meaningful, apart from the directed cases that show a misplaced strobe is ignored. A behavioural model in the bench predicts every output on every cycle, so the conflict and dispatch orderings are checked continuously as well as at the directed points.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PROC = 2'd2
  } trapState_t;

  typedef struct packed {
    logic dispatch;
    logic wipe;
  } ctrlStrobe_t;
endpackage

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int NUM_TRAPS  = 8,
  parameter int HARD_FIRST = 4,
  parameter int ADDR_W     = 24,
  parameter int PRI_BASE   = 'h04,
  parameter int ALT_BASE   = 'h84,
  parameter int SLOT_STEP  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TRAPS-1:0] trapReq,
  input  logic                 altSel,
  input  ctrlStrobe_t          strobe,
  input  logic                 busy,
  output logic [NUM_TRAPS-1:0] pending,
  output logic                 anyPending,
  output logic                 hardPending,
  output logic                 winHard,
  output logic                 conflict,
  output logic                 vecValid,
  output logic [ADDR_W-1:0]    vecAddr
);
  localparam int IDX_W = $clog2(NUM_TRAPS);

  logic [IDX_W-1:0]     winIdx;
  logic [IDX_W-1:0]     actIdx;
  logic [NUM_TRAPS-1:0] clrMask;
  logic [ADDR_W-1:0]    tableBase;

  // fixed priority: highest set bit wins
  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_TRAPS; i++)
      if (pending[i]) winIdx = IDX_W'(i);
  end

  // a hard request below something already pending or active is a conflict
  always_comb begin
    conflict = 1'b0;
    for (int i = HARD_FIRST; i < NUM_TRAPS; i++)
      if (trapReq[i] && ((busy && actIdx > IDX_W'(i)) || (|(pending >> (i + 1)))))
        conflict = 1'b1;
  end

  assign anyPending  = |pending;
  assign hardPending = |pending[NUM_TRAPS-1:HARD_FIRST];
  assign winHard     = winIdx >= IDX_W'(HARD_FIRST);
  assign clrMask     = strobe.dispatch ? (NUM_TRAPS'(1) << winIdx) : '0;
  assign tableBase   = altSel ? ADDR_W'(ALT_BASE) : ADDR_W'(PRI_BASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      actIdx   <= '0;
      vecValid <= 1'b0;
      vecAddr  <= '0;
    end else begin
      vecValid <= strobe.dispatch && !strobe.wipe;
      if (strobe.wipe) pending <= '0;
      else             pending <= (pending & ~clrMask) | trapReq;
      if (strobe.dispatch) begin
        actIdx  <= winIdx;
        vecAddr <= tableBase + ADDR_W'(winIdx) * ADDR_W'(SLOT_STEP);
      end
    end
  end

  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid); // R4
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wipe && !strobe.dispatch) |=> ((pending & $past(pending)) == $past(pending))); // R2
endmodule

// File: rtl/trap_control.sv
module trap_control
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPending,
  input  logic        hardPending,
  input  logic        winHard,
  input  logic        conflict,
  input  logic        ack,
  input  logic        trapRet,
  input  logic        flagClr,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        stall,
  output logic        rstReq,
  output logic        trapRstFlag
);
  trapState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (conflict) stateNext = ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (anyPending) stateNext = winHard ? ST_WAIT : ST_PROC;
        ST_WAIT: if (ack)        stateNext = ST_PROC;
        ST_PROC: if (trapRet)    stateNext = ST_IDLE;
        default:                 stateNext = ST_IDLE;
      endcase
    end
  end

  assign strobe.dispatch = (state == ST_IDLE) && anyPending && !conflict;
  assign strobe.wipe     = conflict;
  assign busy            = state != ST_IDLE;
  assign stall           = (state == ST_WAIT) || ((state == ST_IDLE) && hardPending);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      rstReq      <= 1'b0;
      trapRstFlag <= 1'b0;
    end else begin
      state  <= stateNext;
      rstReq <= conflict;
      if (conflict)     trapRstFlag <= 1'b1;
      else if (flagClr) trapRstFlag <= 1'b0;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R8
  AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> trapRstFlag); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trapRstFlag && !flagClr) |=> trapRstFlag); // R10
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !ack && !conflict) |=> stall); // R5
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int NUM_TRAPS  = 8,
  parameter int HARD_FIRST = 4,
  parameter int ADDR_W     = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TRAPS-1:0] trapReq,
  input  logic                 altSel,
  input  logic                 ack,
  input  logic                 trapRet,
  input  logic                 flagClr,
  output logic                 vecValid,
  output logic [ADDR_W-1:0]    vecAddr,
  output logic                 stall,
  output logic                 rstReq,
  output logic                 trapRstFlag,
  output logic [NUM_TRAPS-1:0] trapPending
);
  ctrlStrobe_t strobe;
  logic busy, anyPending, hardPending, winHard, conflict;

  trap_datapath #(
    .NUM_TRAPS(NUM_TRAPS), .HARD_FIRST(HARD_FIRST), .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .altSel(altSel),
    .strobe(strobe), .busy(busy), .pending(trapPending),
    .anyPending(anyPending), .hardPending(hardPending), .winHard(winHard),
    .conflict(conflict), .vecValid(vecValid), .vecAddr(vecAddr)
  );

  trap_control i_control (
    .clk(clk), .rstN(rstN), .anyPending(anyPending), .hardPending(hardPending),
    .winHard(winHard), .conflict(conflict), .ack(ack), .trapRet(trapRet),
    .flagClr(flagClr), .strobe(strobe), .busy(busy), .stall(stall),
    .rstReq(rstReq), .trapRstFlag(trapRstFlag)
  );
endmodule

// File: tb/test_trap_arbiter.sv
module test_trap_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] trapReq = '0;
  logic altSel = 1'b0, ack = 1'b0, trapRet = 1'b0, flagClr = 1'b0;
  logic vecValid, stall, rstReq, trapRstFlag;
  logic [23:0] vecAddr;
  logic [7:0] trapPending;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_arbiter i_trap_arbiter (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .altSel(altSel), .ack(ack),
    .trapRet(trapRet), .flagClr(flagClr), .vecValid(vecValid), .vecAddr(vecAddr),
    .stall(stall), .rstReq(rstReq), .trapRstFlag(trapRstFlag), .trapPending(trapPending)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 waiting for ack, 2 in service
  bit [7:0] mPend;
  int mState, mAct;
  bit mValid, mRst, mFlag;
  logic [23:0] mAddr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend = 0; mState = 0; mAct = 0; mValid = 0; mRst = 0; mFlag = 0; mAddr = 0;
    end else begin
      bit clash;
      clash = 0;
      for (int i = 4; i < 8; i++) begin
        if (trapReq[i]) begin
          if (mState != 0 && mAct > i) clash = 1;
          for (int j = i + 1; j < 8; j++) if (mPend[j]) clash = 1;
        end
      end
      mValid = 0;
      if (clash) begin
        mRst = 1; mFlag = 1; mPend = 0; mState = 0;
      end else begin
        bit [7:0] nextPend;
        mRst = 0;
        if (flagClr) mFlag = 0;
        nextPend = mPend | trapReq;
        if (mState == 0) begin
          if (mPend != 0) begin
            int w;
            w = 0;
            for (int k = 0; k < 8; k++) if (mPend[k]) w = k;
            mValid = 1;
            mAddr = (altSel ? 24'h84 : 24'h04) + 24'(2 * w);
            if (!trapReq[w]) nextPend[w] = 1'b0;
            mAct = w;
            mState = (w >= 4) ? 1 : 2;
          end
        end else if (mState == 1) begin
          if (ack) mState = 2;
        end else if (trapRet) mState = 0;
        mPend = nextPend;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(vecValid, mValid, "R4 vecValid");
      if (mValid) chk(vecAddr, mAddr, "R4 vecAddr");
      chk(trapPending, mPend, "R2 trapPending");
      chk(stall, (mState == 1) || (mState == 0 && mPend[7:4] != 0), "R5 stall");
      chk(rstReq, mRst, "R8 rstReq");
      chk(trapRstFlag, mFlag, "R10 trapRstFlag");
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulseReq(input logic [7:0] v);
    trapReq = v; tick(); trapReq = '0;
  endtask

  task automatic doAck();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic doRet();
    trapRet = 1; tick(); trapRet = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk({vecValid, stall, rstReq, trapRstFlag}, 4'b0, "R1 outputs in reset");
    chk(trapPending, 8'h00, "R1 pending in reset");
    rstN = 1;
    tick(); tick();
    chk({vecValid, stall, rstReq, trapRstFlag}, 4'b0, "R1 outputs after reset");

    // soft arithmetic trap, level 11
    pulseReq(8'h08);
    chk(trapPending, 8'h08, "R2 pending visible");
    chk(stall, 0, "R6 soft pending no stall");
    tick();
    chk(vecValid, 1, "R4 soft dispatch");
    chk(vecAddr, 24'h0A, "R4 soft address");
    chk(stall, 0, "R5 soft no stall");
    tick();
    chk(vecValid, 0, "R4 pulse width");
    doAck();
    doRet(); tick();

    // simultaneous soft and hard requests
    pulseReq(8'h2A);
    chk(trapPending, 8'h2A, "R2 three pending");
    chk(stall, 1, "R6 hard pending stall");
    chk(rstReq, 0, "R9 same-cycle hard no conflict");
    tick();
    chk(vecValid, 1, "R3 dispatch");
    chk(vecAddr, 24'h0E, "R3 stack error wins");
    chk(trapPending, 8'h0A, "R3 others stay pending");
    chk(stall, 1, "R5 stall after hard dispatch");
    doRet();
    chk(stall, 1, "R7 trapRet before ack ignored");
    tick(); tick();
    chk(stall, 1, "R5 stall held without ack");
    doAck();
    chk(stall, 0, "R5 ack releases stall");
    tick(); tick();
    chk(vecValid, 0, "R7 no dispatch while in service");
    chk(trapPending, 8'h0A, "R7 pending held");
    doRet(); tick();
    chk(vecAddr, 24'h0A, "R3 level 11 next");
    chk(trapPending, 8'h02, "R3 lowest remains");
    doAck(); doRet(); tick();
    chk(vecAddr, 24'h06, "R3 level 9 last");
    doRet(); tick();

    // alternate table
    altSel = 1;
    pulseReq(8'h40); tick();
    chk(vecAddr, 24'h90, "R4 alternate oscillator slot");
    doAck(); doRet();
    pulseReq(8'h08); tick();
    chk(vecAddr, 24'h8A, "R4 alternate arithmetic slot");
    doRet();
    altSel = 0; tick();

    // conflict against an active higher hard trap
    pulseReq(8'h40); tick(); doAck();
    pulseReq(8'h10);
    chk(rstReq, 1, "R8 conflict reset request");
    chk(trapRstFlag, 1, "R10 flag set");
    chk(trapPending, 8'h00, "R8 pending cleared");
    chk(stall, 0, "R8 idle after conflict");
    tick();
    chk(rstReq, 0, "R8 one-cycle reset");
    chk(trapRstFlag, 1, "R10 flag sticky");
    pulseReq(8'h01); tick();
    chk(vecAddr, 24'h04, "R8 resumes after conflict");
    doRet(); tick();

    // conflict against a pending higher hard trap, with clear in the same cycle
    pulseReq(8'h80);
    flagClr = 1;
    pulseReq(8'h20);
    flagClr = 0;
    chk(rstReq, 1, "R8 conflict with pending");
    chk(trapRstFlag, 1, "R10 set wins over clear");
    chk(vecValid, 0, "R8 no dispatch on conflict");
    flagClr = 1; tick(); flagClr = 0;
    chk(trapRstFlag, 0, "R10 software clear");
    tick();

    // higher hard trap during a lower one is queued
    pulseReq(8'h10); tick();
    chk(vecAddr, 24'h0C, "R4 address error slot");
    pulseReq(8'h40);
    chk(rstReq, 0, "R9 higher hard no conflict");
    chk(trapPending, 8'h40, "R9 higher hard pending");
    doAck(); doRet(); tick();
    chk(vecAddr, 24'h10, "R9 queued hard dispatched");
    chk(stall, 1, "R5 stall for queued hard");
    doAck(); doRet();
    repeat (3) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule